// File: doc/BRIEF.md
# UART Buffer and Status Flag Controller

This block owns the receive and transmit data buffers of a UART and the three status flags around them: receive-buffer-full, transmit-buffer-empty and overrun. It sits between an 8-bit register bus and the serial shifters. The bus side has read and write strobes and one select line each for the status register, the receive buffer and the transmit buffer. On the serial side, the receive shifter pulses `rx_done` with a finished byte. The transmit shifter holds `tx_req` high while it is idle and can accept a byte.

Every flag clears through a two-step handshake. A status read arms only those flags that read as 1 at that moment. A later buffer access then clears only the armed flags and disarms them. Because of this, an overrun that happens between the status read and the receive-buffer read is kept, and software sees it on its next status read. While the overrun flag is set, new frames are dropped and the receive buffer keeps the byte it already holds.

Top module: `uart_bufstat`

## Requirements
- R1: A frame finishing while both receive-buffer-full and overrun are 0 loads `rx_byte` into the receive buffer. After that edge, receive-buffer-full is 1 and `irq_rx` is high for the next cycle.
- R2: Receive-buffer-full clears only on a receive-buffer read that follows a status read which saw the flag at 1. A receive-buffer read with no armed flag leaves the flag unchanged.
- R3: While `tx_req` is 1 and transmit-buffer-empty is 0, `tx_load` is 1 in the same cycle and `tx_byte` carries the buffered byte. After that edge, transmit-buffer-empty is 1 and `irq_tx` is high for one cycle.
- R4: A transmit-buffer write is accepted only when transmit-buffer-empty is 1 and was armed by an earlier status read. An accepted write stores `wdata` and clears the flag. Any other write is ignored, and every transmit-buffer write disarms the flag.
- R5: A frame finishing while receive-buffer-full is 1 and overrun is 0 sets overrun and still pulses `irq_rx`.
- R6: Overrun clears on a receive-buffer read that follows a status read which saw overrun at 1.
- R7: While overrun is 1, finished frames are dropped: there is no `irq_rx` and the buffer does not change.
- R8: When an overrun occurs, the receive buffer keeps its earlier byte and the new byte is lost.
- R9: An overrun set after a status read that saw it at 0 is not cleared by the receive-buffer read that follows.
- R10: After reset, receive-buffer-full and overrun are 0 and transmit-buffer-empty is 1. A status read returns bit 0 = receive-buffer-full, bit 1 = transmit-buffer-empty, bit 2 = overrun, and bits 7:3 = 0. `rdata` is 0 when `bus_rd` is low.
- R11: A clearing receive-buffer read and a finished frame in the same cycle load the new byte, leave receive-buffer-full at 1 and set no overrun.
- R12: `irq_rx` and `irq_tx` are one-cycle pulses for each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| sel_stat | input | 1 | Selects the status register |
| sel_rxb | input | 1 | Selects the receive buffer |
| sel_txb | input | 1 | Selects the transmit buffer |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_done | input | 1 | Receive shifter frame-complete pulse |
| rx_byte | input | 8 | Byte delivered with `rx_done` |
| tx_req | input | 1 | Transmit shifter idle and requesting a byte |
| tx_load | output | 1 | Byte handed to the transmit shifter this cycle |
| tx_byte | output | 8 | Transmit buffer content |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit interrupt pulse |

## Verification
The bench goes after the arming rules. A receive read with no prior status read must leave the full flag set; a design that clears on any read would drop it. An overrun that arrives after the status read must survive the next buffer read; a design that arms all flags together would lose that error. The bench also covers frames that arrive during an overrun, which would otherwise overwrite the saved byte. It checks a frame that lands in the same cycle as a clearing read, which a design with the wrong priority would report as a false overrun. Finally, it checks writes to a full or unarmed transmit buffer, which a careless design would let overwrite a byte waiting to be sent.

// File: rtl/uart_bufstat.sv
module uart_bufstat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic         sel_stat,
  input  logic         sel_rxb,
  input  logic         sel_txb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         rx_done,
  input  logic [W-1:0] rx_byte,
  input  logic         tx_req,
  output logic         tx_load,
  output logic [W-1:0] tx_byte,
  output logic         irq_rx,
  output logic         irq_tx
);

  logic         rx_full, tx_empty, ovr;
  logic         arm_rf, arm_te, arm_ov;
  logic [W-1:0] rxbuf, txbuf;

  logic rd_stat, rd_rxb, wr_txb;
  logic full_eff, ovr_eff, rx_take, rx_ovr, tx_take;

  assign rd_stat  = bus_rd & sel_stat;
  assign rd_rxb   = bus_rd & sel_rxb & ~sel_stat;
  assign wr_txb   = bus_wr & sel_txb;

  assign full_eff = rx_full & ~(rd_rxb & arm_rf);
  assign ovr_eff  = ovr & ~(rd_rxb & arm_ov);
  assign rx_take  = rx_done & ~ovr_eff & ~full_eff;
  assign rx_ovr   = rx_done & ~ovr_eff & full_eff;

  assign tx_load  = tx_req & ~tx_empty;
  assign tx_take  = wr_txb & tx_empty & arm_te;
  assign tx_byte  = txbuf;

  always_comb begin
    rdata = '0;
    if (rd_stat)     rdata = {{(W-3){1'b0}}, ovr, tx_empty, rx_full};
    else if (rd_rxb) rdata = rxbuf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full  <= 1'b0;
      ovr      <= 1'b0;
      tx_empty <= 1'b1;
      arm_rf   <= 1'b0;
      arm_ov   <= 1'b0;
      arm_te   <= 1'b0;
      rxbuf    <= '0;
      txbuf    <= '0;
      irq_rx   <= 1'b0;
      irq_tx   <= 1'b0;
    end else begin
      rx_full <= full_eff | rx_take;
      ovr     <= ovr_eff | rx_ovr;
      irq_rx  <= rx_take | rx_ovr;
      irq_tx  <= tx_load;
      if (rx_take) rxbuf <= rx_byte;
      if (tx_take) txbuf <= wdata;
      if (tx_load)      tx_empty <= 1'b1;
      else if (tx_take) tx_empty <= 1'b0;
      if (rd_stat) begin
        arm_rf <= rx_full;
        arm_ov <= ovr;
        arm_te <= tx_empty;
      end else begin
        if (rd_rxb) begin
          arm_rf <= 1'b0;
          arm_ov <= 1'b0;
        end
        if (wr_txb) arm_te <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_bufstat_chk.sv
module uart_bufstat_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_rd,
  input logic         bus_wr,
  input logic         sel_rxb,
  input logic         sel_txb,
  input logic         rx_done,
  input logic         rx_full,
  input logic         tx_empty,
  input logic         ovr,
  input logic         arm_ov,
  input logic [W-1:0] rxbuf,
  input logic         tx_load,
  input logic         irq_tx
);

  AST_RXFULL_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(bus_rd && sel_rxb)); // R2

  AST_TXEMPTY_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(bus_wr && sel_txb)); // R4

  AST_TX_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_empty); // R3

  AST_OVR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_done && rx_full)); // R5

  AST_OVR_FALL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(arm_ov && bus_rd && sel_rxb)); // R9

  AST_RXBUF_FROZEN_IN_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovr) && ovr) |-> $stable(rxbuf)); // R7

  AST_IRQ_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |=> !irq_tx); // R12

endmodule

bind uart_bufstat uart_bufstat_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .sel_rxb(sel_rxb), .sel_txb(sel_txb), .rx_done(rx_done),
  .rx_full(rx_full), .tx_empty(tx_empty), .ovr(ovr), .arm_ov(arm_ov),
  .rxbuf(rxbuf), .tx_load(tx_load), .irq_tx(irq_tx)
);

// File: tb/test_uart_bufstat.sv
module test_uart_bufstat;
  logic       clk = 0, rst_n = 0;
  logic       bus_rd = 0, bus_wr = 0, sel_stat = 0, sel_rxb = 0, sel_txb = 0;
  logic [7:0] wdata = 0, rdata, rx_byte = 0, tx_byte;
  logic       rx_done = 0, tx_req = 0, tx_load, irq_rx, irq_tx;

  int tests = 0, fails = 0;
  logic [7:0] s_rd, s_byte;
  logic s_load, s_irx, s_itx;

  uart_bufstat i_uart_bufstat (.*);

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(bit rd, bit st, bit rb, bit wr, bit tb, logic [7:0] wd,
                       bit dn, logic [7:0] by, bit rq);
    @(negedge clk);
    bus_rd = rd; sel_stat = st; sel_rxb = rb; bus_wr = wr; sel_txb = tb;
    wdata = wd; rx_done = dn; rx_byte = by; tx_req = rq;
    #2;
    s_rd = rdata; s_load = tx_load; s_byte = tx_byte;
    @(posedge clk); #1;
    s_irx = irq_rx; s_itx = irq_tx;
  endtask

  task automatic idle();              drive(0,0,0,0,0,0,0,0,0); endtask
  task automatic stat_rd();           drive(1,1,0,0,0,0,0,0,0); endtask
  task automatic rxb_rd();            drive(1,0,1,0,0,0,0,0,0); endtask
  task automatic txb_wr(logic [7:0] v); drive(0,0,0,1,1,v,0,0,0); endtask
  task automatic frame(logic [7:0] v);  drive(0,0,0,0,0,0,1,v,0); endtask
  task automatic txreq();             drive(0,0,0,0,0,0,0,0,1); endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    drive(0,1,0,0,0,0,0,0,0); check("R10 rdata without strobe", s_rd, 0);
    stat_rd();                check("R10 reset status", s_rd, 8'h02);

    for (int v = 0; v < 256; v++) begin
      stat_rd();
      txb_wr(8'(v));
      stat_rd(); check("R4 armed write clears empty", s_rd, 8'h00);
      txreq();
      check("R3 tx_load", s_load, 1);
      check("R3 tx_byte", s_byte, v);
      check("R3 irq_tx", s_itx, 1);
      idle();    check("R12 irq_tx pulse", s_itx, 0);
    end

    for (int v = 0; v < 256; v++) begin
      frame(8'(v)); check("R1 irq_rx", s_irx, 1);
      idle();       check("R12 irq_rx pulse", s_irx, 0);
      stat_rd();    check("R1 full set", s_rd, 8'h03);
      rxb_rd();     check("R1 data", s_rd, v);
      stat_rd();    check("R2 cleared", s_rd, 8'h02);
    end

    frame(8'h5A);
    rxb_rd();  check("R2 unarmed read data", s_rd, 8'h5A);
    stat_rd(); check("R2 unarmed read keeps full", s_rd, 8'h03);
    rxb_rd();
    stat_rd(); check("R2 armed read clears", s_rd, 8'h02);

    frame(8'h11);
    frame(8'h22); check("R5 irq on overrun", s_irx, 1);
    stat_rd();    check("R5 overrun set", s_rd, 8'h07);
    frame(8'h33); check("R7 no irq while overrun", s_irx, 0);
    rxb_rd();     check("R8 earlier byte kept", s_rd, 8'h11);
    stat_rd();    check("R6 overrun cleared", s_rd, 8'h02);

    frame(8'h44);
    stat_rd();    check("R9 armed full only", s_rd, 8'h03);
    frame(8'h55);
    rxb_rd();     check("R9 data", s_rd, 8'h44);
    stat_rd();    check("R9 late overrun kept", s_rd, 8'h06);
    rxb_rd();     check("R7 buffer unchanged", s_rd, 8'h44);
    stat_rd();    check("R6 overrun cleared late", s_rd, 8'h02);

    frame(8'h66);
    stat_rd();
    drive(1,0,1,0,0,0,1,8'h77,0); check("R11 read old byte", s_rd, 8'h66);
    check("R11 irq", s_irx, 1);
    stat_rd();    check("R11 no overrun, full", s_rd, 8'h03);
    rxb_rd();     check("R11 new byte", s_rd, 8'h77);
    stat_rd();    check("R11 cleared", s_rd, 8'h02);

    txb_wr(8'hA1);
    stat_rd();    check("R4 accepted", s_rd, 8'h00);
    txb_wr(8'hB2);
    txreq();      check("R4 write while full ignored", s_byte, 8'hA1);
    txb_wr(8'hC3);
    stat_rd();    check("R4 unarmed write ignored", s_rd, 8'h02);
    txreq();      check("R4 no load after ignored write", s_load, 0);
    idle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule